// File: doc/BRIEF.md
# Ring-Oscillator Thermal Sensor Controller

This block runs one temperature channel whose sensor is a free-running oscillator. Its frequency rises with die temperature. On a repeating schedule set by a period field M, the controller opens a gate N reference-clock cycles long. It counts oscillator rising edges in a counter clocked by the oscillator itself. After a short settling gap it captures the frozen count into the reference domain. Software reads the capture as a 16-bit value next to a validity bit.

Each capture is compared with three rising count thresholds to give a thermal level from 0 (cool) to 3 (critical). Level 1 and above may request frequency scaling. Level 2 and above may request a halved core clock. Level 3 may request an emergency power-off. Each request has its own enable. A sticky pending bit drives an interrupt line. It is set by a saturated count, by a level of 2 or more, or by level 3, each under its own enable. Software clears it by writing back the status word it read. Access is through a plain word-wide register port: writes take effect on the clock edge and reads are combinational.

Top module: `thermo_ro_ctrl`

## Requirements
- R1: After reset the control word is zero, so the channel does not measure. The status word (address 3) and the count word (address 4) read 0, and irq, scale_req, halve_req and trip_req are all low.
- R2: The control word is at address 0, with stop at bit 0, N at [15:8] and M at [31:16]. With stop clear, N non-zero and M greater than N+4, a capture completes every M reference cycles. It sets the valid bit (status bit 4) and holds a count within 3 of N × f_osc / f_ref. The oscillator is required to run at least as fast as the reference clock.
- R3: With N equal to 0, or M not greater than N+4 (M equal to 0 included), no capture ever completes and the valid bit stays 0.
- R4: The count sits in bits [31:16] of address 4. It changes only at a capture, never during a counting window, so software never sees a partial count.
- R5: Any write to the control word clears the valid bit. While stop is set, valid stays 0, the last count is kept unchanged, and no request output is asserted.
- R6: The count saturates at 0xFFFF. A valid saturated count reads status bits [2:0] as 5.
- R7: The thresholds are TH1 at address 1 bits [15:0], TH2 at address 1 bits [31:16] and TH3 at address 2 bits [15:0]. At each capture the level becomes the highest k for which count ≥ THk, or 0 if there is none. When not saturated, the level reads in status bits [2:0], and it follows the count both up and down.
- R8: With valid set, scale_req = level ≥ 1 AND control bit 4, halve_req = level ≥ 2 AND control bit 5, and trip_req = level 3 AND control bit 6. A disabled request stays low.
- R9: At a capture, status bit 7 (the pending bit, also driven on irq) is set if the count saturated with control bit 1, if the level is ≥ 2 with control bit 2, or if the level is 3 with control bit 3. It is not set when the matching enables are clear.
- R10: Writing address 3 with bit 7 set clears the pending bit, unless a capture raises it in the same cycle. Writing 0 in bit 7 leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| osc_in | input | 1 | Sensor oscillator, used as the counting clock |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, equal to the pending bit |
| scale_req | output | 1 | Frequency-scaling request |
| halve_req | output | 1 | Clock halving request |
| trip_req | output | 1 | Emergency power-off request |

## Verification
The bench targets the moments around a capture. It checks that the count stays frozen for M-1 cycles and then steps to the new value. A design that captured mid-window, or at the wrong slot, would show a partial or early count. It walks the level down as well as up, which exposes a level that only ever rises. It also programs periods too short to hold the window plus the settling gap; a design that accepted those would report valid with a count still being written. The oscillator is run fast enough to saturate, and the bench checks that the status code becomes 5 while the request enables stay independent. It clears the interrupt both with and without bit 7, which catches a pending bit that clears on any status write or never clears.

// File: rtl/thermo_ro_ctrl.sv
`timescale 1ps/1ps
module thermo_ro_ctrl #(
  parameter int SETTLE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_in,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        scale_req,
  output logic        halve_req,
  output logic        trip_req
);
  localparam int CW = 16;
  localparam logic [CW-1:0] SAT = '1;
  localparam logic [2:0] ST_OVF = 3'd5;

  logic [31:0]   ctrl_q, lim_a_q;
  logic [CW-1:0] lim_b_q, pcnt_q, count_q;
  logic          win_q, valid_q, pend_q;
  logic [1:0]    level_q, lvl_new;

  wire ctrl_wr = bus_we && (bus_addr == 3'd0);
  wire stat_wr = bus_we && (bus_addr == 3'd3);
  wire halt = ctrl_q[0];
  wire [7:0] win_len = ctrl_q[15:8];
  wire [CW-1:0] period = ctrl_q[31:16];
  wire [CW-1:0] win_ext = {8'd0, win_len};
  wire running = !halt && (period != '0) && (win_len != 8'd0);
  wire [CW-1:0] cap_at = win_ext + CW'(SETTLE);
  wire cap = running && !ctrl_wr && (pcnt_q == cap_at);

  // oscillator domain: gated edge counter
  logic en_m, en_s, en_d;
  logic [CW-1:0] osc_cnt;
  always_ff @(posedge osc_in or negedge rst_n) begin
    if (!rst_n) begin
      en_m <= 1'b0;
      en_s <= 1'b0;
      en_d <= 1'b0;
      osc_cnt <= '0;
    end else begin
      en_m <= win_q;
      en_s <= en_m;
      en_d <= en_s;
      if (en_s && !en_d)
        osc_cnt <= '0;
      else if (en_s && osc_cnt != SAT)
        osc_cnt <= osc_cnt + 1'b1;
    end
  end

  always_comb begin
    if (osc_cnt >= lim_b_q)               lvl_new = 2'd3;
    else if (osc_cnt >= lim_a_q[31:16])   lvl_new = 2'd2;
    else if (osc_cnt >= lim_a_q[15:0])    lvl_new = 2'd1;
    else                                  lvl_new = 2'd0;
  end

  wire sat_new = (osc_cnt == SAT);
  wire raise = (sat_new && ctrl_q[1]) || (lvl_new[1] && ctrl_q[2]) ||
               ((lvl_new == 2'd3) && ctrl_q[3]);

  // reference domain: schedule, capture, registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      lim_a_q <= '0;
      lim_b_q <= '0;
      pcnt_q  <= '0;
      win_q   <= 1'b0;
      valid_q <= 1'b0;
      count_q <= '0;
      level_q <= 2'd0;
      pend_q  <= 1'b0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          3'd0: ctrl_q  <= bus_wdata;
          3'd1: lim_a_q <= bus_wdata;
          3'd2: lim_b_q <= bus_wdata[15:0];
          default: ;
        endcase
      end

      if (!running || ctrl_wr)
        pcnt_q <= '0;
      else if (pcnt_q == period - 16'd1)
        pcnt_q <= '0;
      else
        pcnt_q <= pcnt_q + 16'd1;

      win_q <= running && !ctrl_wr && (pcnt_q < win_ext);

      if (!running || ctrl_wr)
        valid_q <= 1'b0;
      else if (cap)
        valid_q <= 1'b1;

      if (cap) begin
        count_q <= osc_cnt;
        level_q <= lvl_new;
      end

      if (cap && raise)
        pend_q <= 1'b1;
      else if (stat_wr && bus_wdata[7])
        pend_q <= 1'b0;
    end
  end

  wire [2:0] state = (valid_q && count_q == SAT) ? ST_OVF : {1'b0, level_q};

  assign scale_req = valid_q && ctrl_q[4] && (level_q != 2'd0);
  assign halve_req = valid_q && ctrl_q[5] && level_q[1];
  assign trip_req  = valid_q && ctrl_q[6] && (level_q == 2'd3);
  assign irq = pend_q;

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = ctrl_q;
      3'd1: bus_rdata = lim_a_q;
      3'd2: bus_rdata = {16'd0, lim_b_q};
      3'd3: bus_rdata = {24'd0, pend_q, 2'b00, valid_q, 1'b0, state};
      3'd4: bus_rdata = {count_q, 16'd0};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/thermo_ro_ctrl_chk.sv
`timescale 1ps/1ps
module thermo_ro_ctrl_chk #(
  parameter int SETTLE = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic        wclr,
  input logic        halt,
  input logic [7:0]  win_len,
  input logic [15:0] period,
  input logic [15:0] count_q,
  input logic        win_q,
  input logic        valid_q,
  input logic        cap,
  input logic [2:0]  state,
  input logic        irq,
  input logic        trip_req
);
  // R3: a programming that cannot fit window plus settle never yields valid
  a_r3_bad_prog_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_len == 8'd0) || (period <= ({8'd0, win_len} + 16'(SETTLE)))) |-> !valid_q);

  // R4: captured count is frozen while the gate is open
  a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    win_q |=> $stable(count_q));

  // R5: stop drops valid
  a_r5_stop_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !valid_q);

  // R8: power-off request only with a level-3 or saturated state
  a_r8_trip_state: assert property (@(posedge clk) disable iff (!rst_n)
    trip_req |-> ((state == 3'd3) || (state == 3'd5)));

  // R10: write-back with bit 7 clears pending when no capture collides
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == 3'd3) && wclr && !cap) |=> !irq);
endmodule

bind thermo_ro_ctrl thermo_ro_ctrl_chk #(.SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wclr(bus_wdata[7]), .halt(ctrl_q[0]), .win_len(ctrl_q[15:8]),
  .period(ctrl_q[31:16]), .count_q(count_q), .win_q(win_q),
  .valid_q(valid_q), .cap(cap), .state(state), .irq(irq),
  .trip_req(trip_req)
);

// File: tb/thermo_ro_ctrl_tb.sv
`timescale 1ps/1ps
module thermo_ro_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq, scale_req, halve_req, trip_req;

  int osc_half = 500;
  int checks = 0;
  int errors = 0;

  // osc period (ps), window N, expected count, expected level
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{1000,  20,  100, 0},
    '{1000,  40,  200, 1},
    '{ 500,  50,  500, 2},
    '{ 250,  60, 1200, 3},
    '{1000,  20,  100, 0},
    '{2500, 100,  200, 1}
  };

  always #2500 clk = ~clk;
  initial forever #(osc_half) osc = ~osc;

  thermo_ro_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .scale_req(scale_req), .halve_req(halve_req),
    .trip_req(trip_req)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_valid(input int lim, output bit seen);
    logic [31:0] d;
    seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      rd(3'd3, d);
      if (d[4]) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  function automatic int absdiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, keep;
    bit seen;
    int c0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd3, d); chk(d == 0, "R1 status after reset", d, 0);
    rd(3'd4, d); chk(d == 0, "R1 count after reset", d, 0);
    chk({irq, scale_req, halve_req, trip_req} == 4'b0, "R1 outputs after reset",
        {irq, scale_req, halve_req, trip_req}, 0);

    wr(3'd1, {16'd400, 16'd150});
    wr(3'd2, 32'd900);
    rd(3'd1, d); chk(d == {16'd400, 16'd150}, "R7 threshold readback", d, {16'd400, 16'd150});

    // vector walk: R2 count, R7 level both directions, R8 responses, R9 irq
    for (int i = 0; i < NV; i++) begin
      int n, ec, el, cnt;
      n = VEC[i][1]; ec = VEC[i][2]; el = VEC[i][3];
      osc_half = VEC[i][0] / 2;
      wr(3'd0, {16'(n + 20), 8'(n), 8'h7E});
      wr(3'd3, 32'h80);
      wait_valid(2000, seen);
      chk(seen, "R2 valid after capture", seen, 1);
      rd(3'd4, d); cnt = int'(d[31:16]);
      chk(absdiff(cnt, ec) <= 3, "R2 count", cnt, ec);
      rd(3'd3, d);
      chk(int'(d[2:0]) == el, "R7 level", d[2:0], el);
      chk(scale_req == (el >= 1), "R8 scale_req", scale_req, el >= 1);
      chk(halve_req == (el >= 2), "R8 halve_req", halve_req, el >= 2);
      chk(trip_req == (el == 3), "R8 trip_req", trip_req, el == 3);
      chk(irq == (el >= 2), "R9 irq", irq, el >= 2);
    end

    // R4 count frozen for M-1 cycles, then steps (R2 periodicity)
    osc_half = 500;
    wr(3'd0, {16'd200, 8'd20, 8'h7E});
    wait_valid(2000, seen);
    chk(seen, "R2 valid M=200", seen, 1);
    rd(3'd4, d); c0 = int'(d[31:16]);
    chk(absdiff(c0, 100) <= 3, "R2 count at 1 GHz", c0, 100);
    osc_half = 250;
    repeat (199) @(negedge clk);
    rd(3'd4, d);
    chk(int'(d[31:16]) == c0, "R4 count held until next capture", d[31:16], c0);
    @(negedge clk);
    rd(3'd4, d);
    chk(absdiff(int'(d[31:16]), 200) <= 3, "R2 next capture after M cycles", d[31:16], 200);
    keep = d;

    // R5 stop
    wr(3'd0, {16'd200, 8'd20, 8'h7F});
    rd(3'd3, d); chk(d[4] == 1'b0, "R5 valid cleared by stop", d[4], 0);
    repeat (400) @(negedge clk);
    rd(3'd4, d); chk(d == keep, "R5 count kept while stopped", d[31:16], keep[31:16]);
    rd(3'd3, d); chk(d[4] == 1'b0, "R5 valid stays low", d[4], 0);
    chk({scale_req, halve_req, trip_req} == 3'b0, "R5 no requests while stopped",
        {scale_req, halve_req, trip_req}, 0);

    // R3 misprogramming
    osc_half = 500;
    wr(3'd0, {16'd30, 8'd26, 8'h7E});
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); rd(3'd3, d); if (d[4]) seen = 1'b1;
    end
    chk(!seen, "R3 M equal N+4 never valid", seen, 0);
    wr(3'd0, {16'd0, 8'd20, 8'h7E});
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); rd(3'd3, d); if (d[4]) seen = 1'b1;
    end
    chk(!seen, "R3 M zero never valid", seen, 0);

    // R6 saturation, overflow interrupt only, power-off disabled
    wr(3'd3, 32'h80);
    osc_half = 5;
    wr(3'd0, {16'd280, 8'd255, 8'h32});
    wait_valid(1000, seen);
    chk(seen, "R6 valid when saturated", seen, 1);
    rd(3'd4, d); chk(d[31:16] == 16'hFFFF, "R6 count saturates", d[31:16], 16'hFFFF);
    rd(3'd3, d); chk(d[2:0] == 3'd5, "R6 state 5", d[2:0], 5);
    chk(irq == 1'b1, "R9 overflow interrupt", irq, 1);
    chk(trip_req == 1'b0, "R8 disabled trip stays low", trip_req, 0);
    chk(halve_req == 1'b1, "R8 halve at level 3", halve_req, 1);

    // R10 write-back clear
    wr(3'd3, 32'h0);
    chk(irq == 1'b1, "R10 bit7 zero keeps pending", irq, 1);
    wr(3'd0, {16'd280, 8'd255, 8'h33});
    osc_half = 125;
    rd(3'd3, d);
    chk(d[7] == 1'b1, "R10 pending visible in status", d[7], 1);
    wr(3'd3, d);
    chk(irq == 1'b0, "R10 write-back clears", irq, 0);

    // R9 no interrupt enables at level 3
    wr(3'd0, {16'd80, 8'd60, 8'h70});
    wait_valid(1000, seen);
    rd(3'd3, d);
    chk(d[2:0] == 3'd3, "R7 level 3 again", d[2:0], 3);
    chk(trip_req == 1'b1, "R8 trip enabled", trip_req, 1);
    chk(irq == 1'b0, "R9 no irq when disabled", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule